// File: doc/BRIEF.md
# Flash Command Sequencer

This block is the command front end of a NOR-style flash memory, with a small behavioural storage array inside it. Each bus write is decoded as a command byte. Some commands take effect at once: they select what reads return, or they clear the error flags. Others open a multi-cycle sequence that needs a confirm write. Block erase is a setup write followed by a confirm. Buffered program is a setup write, a word count, the data words and then a confirm. Once a sequence is confirmed, the block runs its internal phases. Each phase has a fixed length set by a parameter.

A status byte reports ready/busy and the error causes. A read returns either the status byte or array data, registered one cycle after the read strobe. While an operation runs, array reads return a fixed invalid pattern. The ready pin follows the status ready bit. A per-block lock input and a program-voltage-valid input are checked when the confirm write arrives. The program-voltage input is also checked in every busy cycle.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: Block erase is a write of 0x20 followed by a write of 0xD0. The block index comes from the address of the confirm write (address bits above the word field). When the erase completes, every word of that block reads 0xFFFF and other blocks keep their contents.
- R2: If the write that follows 0x20 or the buffered-program data does not carry 0xD0, status bit 5 is set, no operation starts and the array is unchanged.
- R3: Status bit 7 and the ready pin are 0 in every busy cycle and 1 otherwise. With default parameters an erase is busy for 3+8+2 = 13 cycles, and a buffered program of N words for 3+N cycles.
- R4: A buffered program writes the old word AND the new word, so bits can only go from 1 to 0.
- R5: An erase runs three phases in order: precondition (block to all zeros), erase (all ones), verify. An abort during the erase phase leaves the block at 0x0000.
- R6: Starting an erase or a program selects status read mode. That mode stays selected after the operation ends, until a 0xFF write selects array mode.
- R7: A confirm to a locked block aborts with bit 1 set. A program-voltage-invalid condition at confirm or in any busy cycle aborts with bit 3 set. For an erase, bit 5 is set as well; for a program, bit 4 is set as well.
- R8: While any of status bits 5, 4, 3 or 1 is set, 0x20 and 0xE8 writes are ignored.
- R9: While busy, 0xFF selects array mode, and array reads then return 0xBAD0. 0x90, 0x98 and 0xB0 select status mode. Every other write is ignored.
- R10: Buffered program sequence: 0xE8 at the start address; then a write whose data bits [1:0] hold N-1; then N data writes, each with its own address; then 0xD0. The array changes only after the confirm.
- R11: A 0x50 write while idle clears status bits 5, 4, 3 and 1. 0x70 selects status mode. Status reads return the status byte in bits [7:0] with zeros above it.
- R12: After reset the block is ready, status is 0x80, array read mode is selected and every word reads 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for a command or data cycle |
| addr | input | 6 | Word address: block index in bits [5:4], word in bits [3:0] |
| wdata | input | 16 | Write data; command code in bits [7:0] |
| rd_en | input | 1 | Read strobe; rdata updates on the next edge |
| blk_lock | input | 4 | Lock flag for each block |
| vpp_ok | input | 1 | Program voltage valid |
| rdata | output | 16 | Registered read data |
| ready | output | 1 | High when no operation is running |

## Verification
Erase is exercised five ways: a clean erase, a sequence broken by a wrong confirm, an erase aimed at a locked block, an erase while the error flags are still set, and an erase whose program voltage drops partway through. Comparing the results separates an aborted erase, an erase that was ignored, and an erase that stopped after preconditioning, because each leaves a different status byte and a different block pattern. Buffered program is run with four words and then with a single overlapping word, which shows the AND behaviour. Commands issued in mid-erase show which writes the busy filter lets through.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
    localparam logic [7:0] OP_RD_ARRAY  = 8'hFF;
    localparam logic [7:0] OP_RD_STATUS = 8'h70;
    localparam logic [7:0] OP_CLR_STAT  = 8'h50;
    localparam logic [7:0] OP_ERASE     = 8'h20;
    localparam logic [7:0] OP_CONFIRM   = 8'hD0;
    localparam logic [7:0] OP_BUF_PROG  = 8'hE8;
    localparam logic [7:0] OP_ID        = 8'h90;
    localparam logic [7:0] OP_QUERY     = 8'h98;
    localparam logic [7:0] OP_SUSPEND   = 8'hB0;

    typedef enum logic [2:0] {
        CMD_NONE, CMD_RD_ARRAY, CMD_RD_STATUS, CMD_CLR,
        CMD_ERASE, CMD_CONFIRM, CMD_BUFPROG, CMD_INFO
    } cmd_e;

    typedef enum logic [3:0] {
        S_IDLE, S_ERS_CONF, S_PB_CNT, S_PB_DATA, S_PB_CONF,
        S_PRE, S_ERS, S_VER, S_PRG, S_COMMIT
    } seq_e;

    typedef enum logic { RM_ARRAY, RM_STATUS } rmode_e;

    typedef enum logic [1:0] { AOP_NONE, AOP_ZERO, AOP_ONES, AOP_PROG } aop_e;

    typedef struct packed {
        logic ready;
        logic rsv6;
        logic ers_err;
        logic prg_err;
        logic vpp_err;
        logic rsv2;
        logic lock_err;
        logic rsv0;
    } status_t;

    function automatic cmd_e decode_op(input logic [7:0] code);
        case (code)
            OP_RD_ARRAY:                   return CMD_RD_ARRAY;
            OP_RD_STATUS:                  return CMD_RD_STATUS;
            OP_CLR_STAT:                   return CMD_CLR;
            OP_ERASE:                      return CMD_ERASE;
            OP_CONFIRM:                    return CMD_CONFIRM;
            OP_BUF_PROG:                   return CMD_BUFPROG;
            OP_ID, OP_QUERY, OP_SUSPEND:   return CMD_INFO;
            default:                       return CMD_NONE;
        endcase
    endfunction

    function automatic logic any_err(input status_t s);
        return s.ers_err | s.prg_err | s.vpp_err | s.lock_err;
    endfunction
endpackage

// File: rtl/fcc_cmd_decode.sv
module fcc_cmd_decode
    import fcc_pkg::*;
(
    input  logic [7:0] code,
    output cmd_e       cmd
);
    always_comb cmd = decode_op(code);
endmodule

// File: rtl/fcc_array.sv
module fcc_array
    import fcc_pkg::*;
#(
    parameter int BLOCKS = 4,
    parameter int WORDS  = 16,
    parameter int DATA_W = 16
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  aop_e                                  op,
    input  logic [$clog2(BLOCKS)-1:0]             op_blk,
    input  logic [$clog2(BLOCKS*WORDS)-1:0]       prog_addr,
    input  logic [DATA_W-1:0]                     prog_data,
    input  logic [$clog2(BLOCKS*WORDS)-1:0]       rd_addr,
    output logic [DATA_W-1:0]                     rd_data
);
    localparam int DEPTH = BLOCKS * WORDS;
    localparam int WRD_W = $clog2(WORDS);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else begin
            case (op)
                AOP_ZERO: for (int w = 0; w < WORDS; w++) mem[{op_blk, WRD_W'(w)}] <= '0;
                AOP_ONES: for (int w = 0; w < WORDS; w++) mem[{op_blk, WRD_W'(w)}] <= '1;
                AOP_PROG: mem[prog_addr] <= mem[prog_addr] & prog_data;
                default:  ;
            endcase
        end
    end

    assign rd_data = mem[rd_addr];

    // R1: an erase pulse leaves the block's first word at all ones
    assert_erase_ones_R1: assert property (@(posedge clk) disable iff (rst)
        (op == AOP_ONES) |=> (mem[{$past(op_blk), {WRD_W{1'b0}}}] == '1));
    // R5: a precondition pulse leaves the block's first word at zero
    assert_precond_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (op == AOP_ZERO) |=> (mem[{$past(op_blk), {WRD_W{1'b0}}}] == '0));
endmodule

// File: rtl/fcc_seq.sv
module fcc_seq
    import fcc_pkg::*;
#(
    parameter int BLOCKS    = 4,
    parameter int WORDS     = 16,
    parameter int DATA_W    = 16,
    parameter int BUF_DEPTH = 4,
    parameter int PRE_CYC   = 3,
    parameter int ERS_CYC   = 8,
    parameter int VER_CYC   = 2,
    parameter int PRG_CYC   = 3
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  wr_en,
    input  logic [$clog2(BLOCKS*WORDS)-1:0]       addr,
    input  logic [DATA_W-1:0]                     wdata,
    input  cmd_e                                  cmd,
    input  logic [BLOCKS-1:0]                     blk_lock,
    input  logic                                  vpp_ok,
    output status_t                               status,
    output rmode_e                                rmode,
    output logic                                  busy,
    output aop_e                                  aop,
    output logic [$clog2(BLOCKS)-1:0]             aop_blk,
    output logic [$clog2(BLOCKS*WORDS)-1:0]       prog_addr,
    output logic [DATA_W-1:0]                     prog_data
);
    localparam int ADDR_W = $clog2(BLOCKS*WORDS);
    localparam int BLK_W  = $clog2(BLOCKS);
    localparam int WRD_W  = $clog2(WORDS);
    localparam int IDX_W  = $clog2(BUF_DEPTH);
    localparam int MAXC   = (PRE_CYC > ERS_CYC ? PRE_CYC : ERS_CYC) + VER_CYC + PRG_CYC;
    localparam int CW     = $clog2(MAXC + 1);

    seq_e              state;
    logic [CW-1:0]     cnt;
    logic [BLK_W-1:0]  blk_q;
    logic [IDX_W-1:0]  idx, buf_last;
    logic [ADDR_W-1:0] buf_a [BUF_DEPTH];
    logic [DATA_W-1:0] buf_d [BUF_DEPTH];
    logic [BLK_W-1:0]  blk_in;
    logic              last;

    assign blk_in = addr[ADDR_W-1:WRD_W];
    assign busy   = state inside {S_PRE, S_ERS, S_VER, S_PRG, S_COMMIT};

    always_comb begin
        case (state)
            S_PRE:   last = (cnt == CW'(PRE_CYC - 1));
            S_ERS:   last = (cnt == CW'(ERS_CYC - 1));
            S_VER:   last = (cnt == CW'(VER_CYC - 1));
            S_PRG:   last = (cnt == CW'(PRG_CYC - 1));
            default: last = 1'b0;
        endcase
    end

    always_comb begin
        aop       = AOP_NONE;
        aop_blk   = blk_q;
        prog_addr = buf_a[idx];
        prog_data = buf_d[idx];
        if (vpp_ok) begin
            case (state)
                S_PRE:    if (last) aop = AOP_ZERO;
                S_ERS:    if (last) aop = AOP_ONES;
                S_COMMIT: aop = AOP_PROG;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            cnt      <= '0;
            blk_q    <= '0;
            idx      <= '0;
            buf_last <= '0;
            status   <= status_t'(8'h80);
            rmode    <= RM_ARRAY;
            for (int i = 0; i < BUF_DEPTH; i++) begin
                buf_a[i] <= '0;
                buf_d[i] <= '0;
            end
        end else begin
            case (state)
                S_IDLE: if (wr_en) begin
                    case (cmd)
                        CMD_RD_ARRAY: rmode <= RM_ARRAY;
                        CMD_CLR: begin
                            status.ers_err  <= 1'b0;
                            status.prg_err  <= 1'b0;
                            status.vpp_err  <= 1'b0;
                            status.lock_err <= 1'b0;
                        end
                        CMD_ERASE: if (!any_err(status)) begin
                            state <= S_ERS_CONF;
                            rmode <= RM_STATUS;
                        end
                        CMD_BUFPROG: if (!any_err(status)) begin
                            state <= S_PB_CNT;
                            blk_q <= blk_in;
                            rmode <= RM_STATUS;
                        end
                        default: rmode <= RM_STATUS;
                    endcase
                end
                S_ERS_CONF: if (wr_en) begin
                    state <= S_IDLE;
                    if (cmd != CMD_CONFIRM) begin
                        status.ers_err <= 1'b1;
                    end else if (blk_lock[blk_in]) begin
                        status.lock_err <= 1'b1;
                        status.ers_err  <= 1'b1;
                    end else if (!vpp_ok) begin
                        status.vpp_err <= 1'b1;
                        status.ers_err <= 1'b1;
                    end else begin
                        blk_q        <= blk_in;
                        cnt          <= '0;
                        state        <= S_PRE;
                        status.ready <= 1'b0;
                    end
                end
                S_PB_CNT: if (wr_en) begin
                    buf_last <= wdata[IDX_W-1:0];
                    idx      <= '0;
                    state    <= S_PB_DATA;
                end
                S_PB_DATA: if (wr_en) begin
                    buf_a[idx] <= addr;
                    buf_d[idx] <= wdata;
                    if (idx == buf_last) state <= S_PB_CONF;
                    else                 idx   <= idx + 1'b1;
                end
                S_PB_CONF: if (wr_en) begin
                    state <= S_IDLE;
                    idx   <= '0;
                    if (cmd != CMD_CONFIRM) begin
                        status.ers_err <= 1'b1;
                    end else if (blk_lock[blk_q]) begin
                        status.lock_err <= 1'b1;
                        status.prg_err  <= 1'b1;
                    end else if (!vpp_ok) begin
                        status.vpp_err <= 1'b1;
                        status.prg_err <= 1'b1;
                    end else begin
                        cnt          <= '0;
                        state        <= S_PRG;
                        status.ready <= 1'b0;
                    end
                end
                default: begin
                    if (wr_en) begin
                        if (cmd == CMD_RD_ARRAY)  rmode <= RM_ARRAY;
                        else if (cmd == CMD_INFO) rmode <= RM_STATUS;
                    end
                    if (!vpp_ok) begin
                        status.vpp_err <= 1'b1;
                        if (state inside {S_PRG, S_COMMIT}) status.prg_err <= 1'b1;
                        else                                status.ers_err <= 1'b1;
                        status.ready <= 1'b1;
                        state        <= S_IDLE;
                    end else if (state == S_COMMIT) begin
                        if (idx == buf_last) begin
                            state        <= S_IDLE;
                            status.ready <= 1'b1;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end else if (last) begin
                        cnt <= '0;
                        case (state)
                            S_PRE: state <= S_ERS;
                            S_ERS: state <= S_VER;
                            S_PRG: begin state <= S_COMMIT; idx <= '0; end
                            default: begin state <= S_IDLE; status.ready <= 1'b1; end
                        endcase
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    assert_ready_bit_R3: assert property (@(posedge clk) disable iff (rst)
        busy |-> !status.ready);
    assert_seq_err_R2: assert property (@(posedge clk) disable iff (rst)
        (state == S_ERS_CONF && wr_en && cmd != CMD_CONFIRM) |=> (status.ers_err && !busy));
    assert_status_mode_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (rmode == RM_STATUS));
    assert_vpp_abort_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && !vpp_ok) |=> (!busy && status.vpp_err));
    assert_lockout_R8: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && wr_en && (cmd == CMD_ERASE || cmd == CMD_BUFPROG) && any_err(status))
        |=> (state == S_IDLE));
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import fcc_pkg::*;
#(
    parameter int              BLOCKS       = 4,
    parameter int              WORDS        = 16,
    parameter int              DATA_W       = 16,
    parameter int              BUF_DEPTH    = 4,
    parameter int              PRE_CYC      = 3,
    parameter int              ERS_CYC      = 8,
    parameter int              VER_CYC      = 2,
    parameter int              PRG_CYC      = 3,
    parameter logic [15:0]     INVALID_WORD = 16'hBAD0
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en,
    input  logic [$clog2(BLOCKS*WORDS)-1:0]   addr,
    input  logic [DATA_W-1:0]                 wdata,
    input  logic                              rd_en,
    input  logic [BLOCKS-1:0]                 blk_lock,
    input  logic                              vpp_ok,
    output logic [DATA_W-1:0]                 rdata,
    output logic                              ready
);
    localparam int ADDR_W = $clog2(BLOCKS*WORDS);
    localparam int BLK_W  = $clog2(BLOCKS);

    cmd_e              cmd;
    status_t           status;
    rmode_e            rmode;
    logic              busy;
    aop_e              aop;
    logic [BLK_W-1:0]  aop_blk;
    logic [ADDR_W-1:0] prog_addr;
    logic [DATA_W-1:0] prog_data, arr_rd;

    fcc_cmd_decode u_dec (.code(wdata[7:0]), .cmd(cmd));

    fcc_seq #(
        .BLOCKS(BLOCKS), .WORDS(WORDS), .DATA_W(DATA_W), .BUF_DEPTH(BUF_DEPTH),
        .PRE_CYC(PRE_CYC), .ERS_CYC(ERS_CYC), .VER_CYC(VER_CYC), .PRG_CYC(PRG_CYC)
    ) u_seq (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .cmd(cmd),
        .blk_lock(blk_lock), .vpp_ok(vpp_ok), .status(status), .rmode(rmode),
        .busy(busy), .aop(aop), .aop_blk(aop_blk), .prog_addr(prog_addr),
        .prog_data(prog_data)
    );

    fcc_array #(.BLOCKS(BLOCKS), .WORDS(WORDS), .DATA_W(DATA_W)) u_arr (
        .clk(clk), .rst(rst), .op(aop), .op_blk(aop_blk), .prog_addr(prog_addr),
        .prog_data(prog_data), .rd_addr(addr), .rd_data(arr_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            if (rmode == RM_STATUS) rdata <= {{(DATA_W-8){1'b0}}, status};
            else if (busy)          rdata <= DATA_W'(INVALID_WORD);
            else                    rdata <= arr_rd;
        end
    end

    assign ready = status.ready;

    // R9: an array-mode read taken while busy never returns stored data
    assert_busy_invalid_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && busy && rmode == RM_ARRAY) |=> (rdata == DATA_W'(INVALID_WORD)));
endmodule

// File: tb/flash_cmd_ctrl_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst, wr_en, rd_en, vpp_ok;
    logic [5:0]  addr;
    logic [15:0] wdata, rdata;
    logic [3:0]  blk_lock;
    logic        ready;
    int          checks = 0, errors = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    flash_cmd_ctrl dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rd_en(rd_en),
        .blk_lock(blk_lock), .vpp_ok(vpp_ok), .rdata(rdata), .ready(ready)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [15:0] e, input string tag);
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic wait_ready();
        while (!ready) @(negedge clk);
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (!ready) begin n++; @(negedge clk); end
    endtask

    // monitor: score each registered read against the queued expectation
    initial begin
        forever begin
            @(posedge clk);
            if (rd_en) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL scoreboard empty actual=%h expected=none", rdata);
                end else begin
                    chk(tag_q.pop_front(), {16'h0, rdata}, {16'h0, exp_q.pop_front()});
                end
            end
        end
    end

    initial begin
        #500000;
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
        blk_lock = 4'b1000; vpp_ok = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R12 ready after reset", {31'h0, ready}, 32'h1);
        rd(6'd5, 16'hFFFF, "R12 erased array after reset");
        wr(0, 16'h0070);
        rd(0, 16'h0080, "R12 reset status");
        wr(0, 16'h00FF);

        // R10/R2: program sequence with a wrong confirm
        wr(16, 16'h00E8); wr(16, 16'h0003);
        wr(16, 16'h1234); wr(17, 16'h00FF); wr(18, 16'hF0F0); wr(19, 16'h5A5A);
        wr(16, 16'h0070);
        rd(16, 16'h00A0, "R2 program bad confirm status");
        wr(0, 16'h00FF);
        rd(16, 16'hFFFF, "R10 array unchanged without confirm");
        wr(0, 16'h0050); wr(0, 16'h0070);
        rd(0, 16'h0080, "R11 clear status");

        // R10/R3: four-word program
        wr(16, 16'h00E8); wr(16, 16'h0003);
        wr(16, 16'h1234); wr(17, 16'h00FF); wr(18, 16'hF0F0); wr(19, 16'h5A5A);
        wr(16, 16'h00D0);
        busy_len(n);
        chk("R3 program busy window", n, 32'd7);
        rd(16, 16'h0080, "R6 status mode after program");
        wr(0, 16'h00FF);
        rd(16, 16'h1234, "R10 word 0");
        rd(19, 16'h5A5A, "R10 word 3");
        wr(17, 16'h00E8); wr(17, 16'h0000); wr(17, 16'h0F0F); wr(17, 16'h00D0);
        wait_ready(); wr(0, 16'h00FF);
        rd(17, 16'h000F, "R4 program ANDs data");
        wr(2, 16'h00E8); wr(2, 16'h0000); wr(2, 16'h1111); wr(2, 16'h00D0);
        wait_ready();
        wr(32, 16'h00E8); wr(32, 16'h0000); wr(32, 16'h2222); wr(32, 16'h00D0);
        wait_ready();

        // R1/R3/R6: erase block 1 with the confirm at another word of it
        wr(16, 16'h0020); wr(21, 16'h00D0);
        busy_len(n);
        chk("R3 erase busy window", n, 32'd13);
        rd(0, 16'h0080, "R6 status mode persists after erase");
        wr(0, 16'h00FF);
        rd(16, 16'hFFFF, "R1 erased word 0");
        rd(19, 16'hFFFF, "R1 erased word 3");
        rd(2, 16'h1111, "R1 other block kept");

        // R9: commands during busy
        wr(32, 16'h0020); wr(32, 16'h00D0);
        rd(32, 16'h0000, "R3 status busy");
        wr(32, 16'h00FF);
        rd(32, 16'hBAD0, "R9 array read while busy");
        wr(32, 16'h0020);
        rd(32, 16'hBAD0, "R9 setup ignored while busy");
        wait_ready();
        rd(32, 16'hFFFF, "R1 block 2 erased");

        // R2: erase sequence error
        wr(0, 16'h0020); wr(0, 16'h00FF);
        rd(0, 16'h00A0, "R2 erase bad confirm");
        wr(0, 16'h0050); wr(0, 16'h0070);
        rd(0, 16'h0080, "R11 clear after sequence error");

        // R7/R8: lock abort then lockout
        wr(48, 16'h0020); wr(48, 16'h00D0);
        rd(48, 16'h00A2, "R7 lock abort status");
        wr(0, 16'h0020); wr(0, 16'h00D0);
        chk("R8 erase ignored while errors set", {31'h0, ready}, 32'h1);
        wr(0, 16'h00FF);
        rd(2, 16'h1111, "R8 block kept during lockout");
        wr(0, 16'h0050); wr(0, 16'h0070);
        rd(0, 16'h0080, "R11 clear after lock error");

        // R5/R7: voltage drop in the erase phase
        wr(0, 16'h0020); wr(0, 16'h00D0);
        repeat (4) @(negedge clk);
        vpp_ok = 1'b0;
        @(negedge clk);
        chk("R7 abort returns ready", {31'h0, ready}, 32'h1);
        vpp_ok = 1'b1;
        rd(0, 16'h00A8, "R7 voltage abort status");
        wr(0, 16'h00FF);
        rd(2, 16'h0000, "R5 precondition ran before abort");
        wr(0, 16'h0050);

        // R7: voltage invalid at program confirm
        vpp_ok = 1'b0;
        wr(5, 16'h00E8); wr(5, 16'h0000); wr(5, 16'h0000); wr(5, 16'h00D0);
        vpp_ok = 1'b1;
        chk("R7 program not started", {31'h0, ready}, 32'h1);
        rd(5, 16'h0098, "R7 program voltage error");

        repeat (3) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule